// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the combinational arithmetic and logic unit of a small 16-bit accumulator machine. In one pass it takes the accumulator, one operand, the current condition flags and an 8-bit operation code. It returns a result word, the next value of the condition flags and a write-back enable. The sequencer around it latches the result into the accumulator only when that enable is high, and it always latches the returned flags.

The operations are add, add with carry, subtract, compare, AND, OR, XOR, test, increment, decrement, two's-complement negate, one's-complement NOT, logical shifts and rotates, and unsigned and signed multiply.

- Multiply keeps the low word of the product. Its flags report whether the product overflows the low byte.
- The zero flag of the arithmetic operations is deliberately strict: it is set only when the result is zero and neither carry nor overflow was raised.
- An opcode outside the list leaves the machine untouched.

Top module: `acc_alu`

## Requirements
- R1: ADD (0x01) returns acc + opnd and ADC (0x00) returns acc + opnd + incoming CF, both modulo 2^16 with write-back. CF is the unsigned carry out of bit 15, and OF is set when the true signed sum lies outside -32768..32767. The flag word is {OF, CF, ZF, NF} on bits 3 down to 0.
- R2: SUB (0x4b) returns acc - opnd with write-back. CF is a borrow, 1 exactly when opnd > acc as unsigned numbers, and OF is set when the true signed difference lies outside the 16-bit signed range.
- R3: For every arithmetic operation (add, subtract, compare, increment, decrement, negate, multiply), ZF is 1 only when the 16-bit result is zero and both the new CF and the new OF are 0.
- R4: For arithmetic, logic and multiply operations, NF equals bit 15 of the result.
- R5: AND (0x02), OR (0x21) and XOR (0x4d) return the bitwise combination of acc and opnd with write-back. They clear CF and OF and set ZF exactly when the result is zero.
- R6: CMP (0x07) produces the same result and flags as SUB, and TEST (0x4c) produces the same result and flags as AND. Both drive write-back low.
- R7: INC (0x0d) returns opnd + 1 with add flags, DEC (0x08) returns opnd - 1 with subtract flags, and NEG (0x1e) returns 0 - opnd with subtract flags (CF set for any non-zero opnd, OF set for 0x8000). All three write back.
- R8: NOT (0x20) returns the bitwise inverse of opnd with write-back and passes all four flags through unchanged.
- R9: SL (0x28) and SR (0x29) shift acc left or right, filling with zeros, by the amount in opnd bits 3:0. Opnd bits 15:4 are ignored. Both write back and leave the flags unchanged.
- R10: ROL (0x26) and ROR (0x27) rotate acc around the full 16-bit word by opnd bits 3:0. Both write back and leave the flags unchanged.
- R11: MUL (0x1d) returns the low 16 bits of the unsigned product with write-back. CF and OF are both 1 when the full product exceeds 255 and both 0 otherwise.
- R12: IMUL (0x0b) returns the low 16 bits of the signed product with write-back. CF is 1 when the full signed product lies outside -128..127 and 0 otherwise, and OF is always 0.
- R13: Any other opcode drives write-back low, result 0, and flags equal to the incoming flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 16 | Accumulator value, first operand |
| opnd_i | input | 16 | Second operand or shift/rotate amount |
| flags_i | input | 4 | Current flags {OF, CF, ZF, NF} |
| opcode_i | input | 8 | Operation code |
| result_o | output | 16 | Computed result word |
| flags_o | output | 4 | Next flags {OF, CF, ZF, NF} |
| wb_en_o | output | 1 | Result should be written to the accumulator |

## Verification
The hardest conditions to reach from the ports are the ones that sit on a single bit boundary:

- a result of zero that also carries or overflows, which must leave ZF clear;
- a product that just fits in, or just spills out of, the signed low byte;
- shift amounts whose upper operand bits are set but must be ignored.

The stimulus sweeps a corner set of operand words against every one of the 128 lowest opcode values, so each of these conditions is hit. The corner set covers 0, 1, 0x7f, 0x80, 0xff, 0x100, 0x7fff, 0x8000, 0xffff and amounts like 0x13 and 0xf5. The sweep runs with several incoming flag words, so that pass-through and carry-in are both exercised. A few directed cases then pin the strict zero rule and the sign flag separately.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OPC_W = 8;
    localparam int FLG_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADC  = 8'h00,
        OP_ADD  = 8'h01,
        OP_AND  = 8'h02,
        OP_CMP  = 8'h07,
        OP_DEC  = 8'h08,
        OP_IMUL = 8'h0b,
        OP_INC  = 8'h0d,
        OP_MUL  = 8'h1d,
        OP_NEG  = 8'h1e,
        OP_NOT  = 8'h20,
        OP_OR   = 8'h21,
        OP_ROL  = 8'h26,
        OP_ROR  = 8'h27,
        OP_SL   = 8'h28,
        OP_SR   = 8'h29,
        OP_SUB  = 8'h4b,
        OP_TEST = 8'h4c,
        OP_XOR  = 8'h4d
    } alu_op_e;

    // bit 3 down to 0
    typedef struct packed {
        logic ovf;
        logic cry;
        logic zer;
        logic neg;
    } alu_flags_t;

    // how the flags are formed
    typedef enum logic [2:0] {
        FC_KEEP,
        FC_ARITH,
        FC_LOGIC,
        FC_MULU,
        FC_MULS
    } flag_cls_e;

    // which unit drives the result
    typedef enum logic [1:0] {
        RS_ADD,
        RS_LOG,
        RS_SHF,
        RS_MUL
    } res_sel_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_NOT
    } log_fn_e;

    // adder operand sources
    typedef enum logic [1:0] {
        AX_ACC,
        AX_OPND,
        AX_ZERO
    } add_x_e;

    typedef struct packed {
        flag_cls_e cls;
        res_sel_e  rsel;
        log_fn_e   lfn;
        add_x_e    xsel;
        logic      y_one;
        logic      sub;
        logic      use_cin;
        logic      sh_left;
        logic      sh_rot;
        logic      wr;
        logic      valid;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(input logic [OPC_W-1:0] opc);
        alu_ctl_t c;
        c = '{cls: FC_KEEP, rsel: RS_ADD, lfn: LG_AND, xsel: AX_ACC,
              y_one: 1'b0, sub: 1'b0, use_cin: 1'b0, sh_left: 1'b0,
              sh_rot: 1'b0, wr: 1'b1, valid: 1'b1};
        case (opc)
            OP_ADD:  c.cls = FC_ARITH;
            OP_ADC:  begin c.cls = FC_ARITH; c.use_cin = 1'b1; end
            OP_SUB:  begin c.cls = FC_ARITH; c.sub = 1'b1; end
            OP_CMP:  begin c.cls = FC_ARITH; c.sub = 1'b1; c.wr = 1'b0; end
            OP_INC:  begin c.cls = FC_ARITH; c.xsel = AX_OPND; c.y_one = 1'b1; end
            OP_DEC:  begin c.cls = FC_ARITH; c.xsel = AX_OPND; c.y_one = 1'b1; c.sub = 1'b1; end
            OP_NEG:  begin c.cls = FC_ARITH; c.xsel = AX_ZERO; c.sub = 1'b1; end
            OP_AND:  begin c.cls = FC_LOGIC; c.rsel = RS_LOG; c.lfn = LG_AND; end
            OP_TEST: begin c.cls = FC_LOGIC; c.rsel = RS_LOG; c.lfn = LG_AND; c.wr = 1'b0; end
            OP_OR:   begin c.cls = FC_LOGIC; c.rsel = RS_LOG; c.lfn = LG_OR; end
            OP_XOR:  begin c.cls = FC_LOGIC; c.rsel = RS_LOG; c.lfn = LG_XOR; end
            OP_NOT:  begin c.rsel = RS_LOG; c.lfn = LG_NOT; end
            OP_SL:   begin c.rsel = RS_SHF; c.sh_left = 1'b1; end
            OP_SR:   c.rsel = RS_SHF;
            OP_ROL:  begin c.rsel = RS_SHF; c.sh_left = 1'b1; c.sh_rot = 1'b1; end
            OP_ROR:  begin c.rsel = RS_SHF; c.sh_rot = 1'b1; end
            OP_MUL:  begin c.cls = FC_MULU; c.rsel = RS_MUL; end
            OP_IMUL: begin c.cls = FC_MULS; c.rsel = RS_MUL; end
            default: begin c.wr = 1'b0; c.valid = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cry_o,
    output logic         ovf_o
);
    logic [W-1:0] y_eff;
    logic         c_eff;
    logic         c_out;

    always_comb begin
        y_eff = sub_i ? ~y_i : y_i;
        c_eff = sub_i ? 1'b1 : cin_i;
        {c_out, sum_o} = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
        // subtract reports a borrow
        cry_o = sub_i ? ~c_out : c_out;
        ovf_o = (x_i[W-1] == y_eff[W-1]) && (sum_o[W-1] != x_i[W-1]);
    end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
    parameter int W = 16,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          rot_i,
    output logic [W-1:0]  res_o
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = val_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [W-1:0] cur;
        logic [D-1:0] wrap;
        logic [W-1:0] moved;
        assign cur = stage[k];
        always_comb begin
            if (left_i) begin
                wrap  = rot_i ? cur[W-1:W-D] : '0;
                moved = {cur[W-1-D:0], wrap};
            end else begin
                wrap  = rot_i ? cur[D-1:0] : '0;
                moved = {wrap, cur[W-1:D]};
            end
        end
        assign stage[k+1] = amt_i[k] ? moved : cur;
    end

    assign res_o = stage[SW];
endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
    parameter int W = 16,
    localparam int H = W / 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic [W-1:0] prod_o,
    output logic         spill_o
);
    logic [2*W-1:0] p_u;
    logic [2*W-1:0] p_s;

    always_comb begin
        p_u = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        p_s = $unsigned($signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i}));
        if (signed_i) begin
            prod_o  = p_s[W-1:0];
            spill_o = !((&p_s[2*W-1:H-1]) || !(|p_s[2*W-1:H-1]));
        end else begin
            prod_o  = p_u[W-1:0];
            spill_o = |p_u[2*W-1:H];
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 16,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]     acc_i,
    input  logic [W-1:0]     opnd_i,
    input  logic [FLG_W-1:0] flags_i,
    input  logic [OPC_W-1:0] opcode_i,
    output logic [W-1:0]     result_o,
    output logic [FLG_W-1:0] flags_o,
    output logic             wb_en_o
);
    alu_ctl_t   ctl;
    alu_flags_t fin;
    alu_flags_t fout;
    logic [W-1:0] add_x, add_y, add_r, log_r, shf_r, mul_r, res;
    logic add_c, add_v, mul_spill;

    assign ctl = decode_op(opcode_i);
    assign fin = alu_flags_t'(flags_i);

    always_comb begin
        case (ctl.xsel)
            AX_OPND: add_x = opnd_i;
            AX_ZERO: add_x = '0;
            default: add_x = acc_i;
        endcase
        add_y = ctl.y_one ? W'(1) : opnd_i;
    end

    acc_alu_addsub #(.W(W)) u_add (
        .x_i(add_x), .y_i(add_y), .sub_i(ctl.sub), .cin_i(ctl.use_cin & fin.cry),
        .sum_o(add_r), .cry_o(add_c), .ovf_o(add_v)
    );

    acc_alu_shift #(.W(W)) u_shf (
        .val_i(acc_i), .amt_i(opnd_i[SW-1:0]), .left_i(ctl.sh_left),
        .rot_i(ctl.sh_rot), .res_o(shf_r)
    );

    acc_alu_mul #(.W(W)) u_mul (
        .a_i(acc_i), .b_i(opnd_i), .signed_i(ctl.cls == FC_MULS),
        .prod_o(mul_r), .spill_o(mul_spill)
    );

    always_comb begin
        case (ctl.lfn)
            LG_AND:  log_r = acc_i & opnd_i;
            LG_OR:   log_r = acc_i | opnd_i;
            LG_XOR:  log_r = acc_i ^ opnd_i;
            default: log_r = ~opnd_i;
        endcase
    end

    always_comb begin
        case (ctl.rsel)
            RS_LOG:  res = log_r;
            RS_SHF:  res = shf_r;
            RS_MUL:  res = mul_r;
            default: res = add_r;
        endcase
        if (!ctl.valid) res = '0;
    end

    always_comb begin
        fout = fin;
        case (ctl.cls)
            FC_ARITH: begin fout.cry = add_c; fout.ovf = add_v; end
            FC_LOGIC: begin fout.cry = 1'b0; fout.ovf = 1'b0; end
            FC_MULU:  begin fout.cry = mul_spill; fout.ovf = mul_spill; end
            FC_MULS:  begin fout.cry = mul_spill; fout.ovf = 1'b0; end
            default: ;
        endcase
        if (ctl.cls != FC_KEEP) begin
            fout.zer = (res == '0) && !fout.cry && !fout.ovf;
            fout.neg = res[W-1];
        end
    end

    assign result_o = res;
    assign flags_o  = fout;
    assign wb_en_o  = ctl.wr;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input logic [W-1:0]     acc_i,
    input logic [W-1:0]     opnd_i,
    input logic [FLG_W-1:0] flags_i,
    input logic [OPC_W-1:0] opcode_i,
    input logic [W-1:0]     result_o,
    input logic [FLG_W-1:0] flags_o,
    input logic             wb_en_o
);
    logic is_arith, is_logic, is_keep, is_quiet, is_known;
    logic [2*W-1:0] full_u;

    always_comb begin
        is_arith = opcode_i inside {8'h00, 8'h01, 8'h07, 8'h08, 8'h0d, 8'h1e, 8'h4b, 8'h1d, 8'h0b};
        is_logic = opcode_i inside {8'h02, 8'h21, 8'h4d, 8'h4c};
        is_keep  = opcode_i inside {8'h20, 8'h26, 8'h27, 8'h28, 8'h29};
        is_quiet = opcode_i inside {8'h07, 8'h4c};
        is_known = is_arith || is_logic || is_keep;
        full_u   = {{W{1'b0}}, acc_i} * {{W{1'b0}}, opnd_i};

        // R3
        strict_zero_chk: assert (!is_arith || (flags_o[1] == ((result_o == '0) && !flags_o[2] && !flags_o[3])));
        // R5
        logic_clears_chk: assert (!is_logic || (flags_o[3:2] == 2'b00 && flags_o[1] == (result_o == '0)));
        // R6
        quiet_wb_chk: assert (!is_quiet || !wb_en_o);
        // R8
        keep_flags_chk: assert (!is_keep || (flags_o == flags_i && wb_en_o));
        // R11
        mul_spill_chk: assert (opcode_i != 8'h1d || (flags_o[2] == (full_u > 255)));
        // R13
        unlisted_chk: assert (is_known || (!wb_en_o && flags_o == flags_i && result_o == '0));
    end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i), .opcode_i(opcode_i),
    .result_o(result_o), .flags_o(flags_o), .wb_en_o(wb_en_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCORNER = 16;

    logic        clk = 1'b0;
    logic [15:0] acc, opnd, res;
    logic [3:0]  fl_in, fl_out;
    logic [7:0]  opc;
    logic        wb;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u_dut (
        .acc_i(acc), .opnd_i(opnd), .flags_i(fl_in), .opcode_i(opc),
        .result_o(res), .flags_o(fl_out), .wb_en_o(wb)
    );

    function automatic logic [15:0] corner(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
            3: return 16'h0003;  4: return 16'h0013;  5: return 16'h007f;
            6: return 16'h0080;  7: return 16'h00ff;  8: return 16'h0100;
            9: return 16'h7fff; 10: return 16'h8000; 11: return 16'h8001;
           12: return 16'hffff; 13: return 16'ha5c3; 14: return 16'h00f5;
           default: return 16'h1234;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] o);
        case (o)
            8'h00, 8'h01: return "R1";
            8'h4b: return "R2";
            8'h07, 8'h4c: return "R6";
            8'h02, 8'h21, 8'h4d: return "R5";
            8'h0d, 8'h08, 8'h1e: return "R7";
            8'h20: return "R8";
            8'h28, 8'h29: return "R9";
            8'h26, 8'h27: return "R10";
            8'h1d: return "R11";
            8'h0b: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic model(input logic [7:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic [3:0] f, output logic [15:0] r, output logic [3:0] fo,
                         output logic we);
        longint ua, ub, sa, sb, t;
        logic cf, ov, ar;
        int n;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        n = int'(b[3:0]);
        cf = f[2]; ov = f[3]; ar = 1'b1; we = 1'b1; fo = f; r = 16'h0;
        case (o)
            8'h00, 8'h01: begin
                t = ua + ub + ((o == 8'h00) ? longint'(f[2]) : 0);
                r = t[15:0]; cf = t > 65535;
                t = sa + sb + ((o == 8'h00) ? longint'(f[2]) : 0);
                ov = (t > 32767) || (t < -32768);
            end
            8'h4b, 8'h07: begin
                t = ua - ub; r = t[15:0]; cf = ua < ub;
                t = sa - sb; ov = (t > 32767) || (t < -32768);
                we = (o == 8'h4b);
            end
            8'h0d: begin t = ub + 1; r = t[15:0]; cf = ub == 65535; ov = sb == 32767; end
            8'h08: begin t = ub - 1; r = t[15:0]; cf = ub == 0; ov = sb == -32768; end
            8'h1e: begin t = -ub; r = t[15:0]; cf = ub != 0; ov = sb == -32768; end
            8'h1d: begin t = ua * ub; r = t[15:0]; cf = t > 255; ov = cf; end
            8'h0b: begin t = sa * sb; r = t[15:0]; cf = (t > 127) || (t < -128); ov = 1'b0; end
            8'h02, 8'h4c, 8'h21, 8'h4d: begin
                ar = 1'b0;
                r = (o == 8'h21) ? (a | b) : (o == 8'h4d) ? (a ^ b) : (a & b);
                fo = {2'b00, r == 16'h0, r[15]};
                we = (o != 8'h4c);
            end
            8'h20: begin ar = 1'b0; r = ~b; end
            8'h28: begin ar = 1'b0; r = a << n; end
            8'h29: begin ar = 1'b0; r = a >> n; end
            8'h26: begin ar = 1'b0; r = (a << n) | (a >> (16 - n)); end
            8'h27: begin ar = 1'b0; r = (a >> n) | (a << (16 - n)); end
            default: begin ar = 1'b0; we = 1'b0; end
        endcase
        if (ar) fo = {ov, cf, (r == 16'h0) && !cf && !ov, r[15]};
    endtask

    task automatic apply(input logic [7:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic [3:0] f);
        @(posedge clk);
        #1;
        opc = o; acc = a; opnd = b; fl_in = f;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%02h acc=%04h opnd=%04h fl=%01h actual=%06h expected=%06h",
                     tag, opc, acc, opnd, fl_in, act, exp_v);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 120000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] er;
        logic [3:0]  ef;
        logic        ew;
        logic [3:0]  fset [3];
        fset[0] = 4'h0; fset[1] = 4'hf; fset[2] = 4'ha;

        // idle inputs with an unlisted opcode: nothing written, flags kept (R13)
        apply(8'hff, 16'h0, 16'h0, 4'h5);
        check("R13", {wb, fl_out, res}, {1'b0, 4'h5, 16'h0});

        for (int op = 0; op < 128; op++) begin
            for (int fi = 0; fi < 3; fi++) begin
                for (int i = 0; i < NCORNER; i++) begin
                    for (int j = 0; j < NCORNER; j++) begin
                        apply(op[7:0], corner(i), corner(j), fset[fi]);
                        model(op[7:0], corner(i), corner(j), fset[fi], er, ef, ew);
                        check(tag_of(op[7:0]), {wb, fl_out, res}, {ew, ef, er});
                    end
                end
            end
        end

        // R3: zero result with carry keeps ZF clear
        apply(8'h01, 16'hffff, 16'h0001, 4'h0);
        check("R3", {wb, fl_out, res}, {1'b1, 4'b0100, 16'h0000});
        // R3: exact zero difference sets ZF
        apply(8'h4b, 16'h0005, 16'h0005, 4'hf);
        check("R3", {wb, fl_out, res}, {1'b1, 4'b0010, 16'h0000});
        // R4: signed overflow into bit 15 sets NF and OF
        apply(8'h01, 16'h7fff, 16'h0001, 4'h0);
        check("R4", {wb, fl_out, res}, {1'b1, 4'b1001, 16'h8000});
        // R4: logic result sign
        apply(8'h21, 16'h8000, 16'h0001, 4'h0);
        check("R4", {wb, fl_out, res}, {1'b1, 4'b0001, 16'h8001});
        // R9: upper amount bits ignored, shift by 5
        apply(8'h28, 16'h0001, 16'hfff5, 4'h3);
        check("R9", {wb, fl_out, res}, {1'b1, 4'h3, 16'h0020});
        // R10: rotate right by one wraps bit 0 to bit 15
        apply(8'h27, 16'h0001, 16'h0001, 4'h0);
        check("R10", {wb, fl_out, res}, {1'b1, 4'h0, 16'h8000});
        // R12: -128 fits, 128 does not
        apply(8'h0b, 16'hff80, 16'h0001, 4'h0);
        check("R12", {wb, fl_out, res}, {1'b1, 4'b0001, 16'hff80});
        apply(8'h0b, 16'h0080, 16'h0001, 4'h0);
        check("R12", {wb, fl_out, res}, {1'b1, 4'b0100, 16'h0080});
        // R11: 255 fits, 256 spills
        apply(8'h1d, 16'h00ff, 16'h0001, 4'h0);
        check("R11", {wb, fl_out, res}, {1'b1, 4'b0000, 16'h00ff});
        apply(8'h1d, 16'h0010, 16'h0010, 4'h0);
        check("R11", {wb, fl_out, res}, {1'b1, 4'b1100, 16'h0100});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule